// File: doc/BRIEF.md
# Audio System Clock Ratio Detector

This block watches a free-running master clock against the audio frame clock (word select, one period per sample) and works out how many master-clock cycles make up one frame. The count is classified as one of four oversampling ratios, 256, 384, 512 or 768 times the sample rate, with no configuration input. The block reports the ratio as a two-bit code and raises a locked flag once the measurement has settled.

It also produces a single-cycle enable at 64 times the sample rate by dividing the master clock by the ratio over 64. Downstream serial logic uses this enable to run its bit clock. When the block is told it is the frame master, detection is bypassed: the ratio is fixed at 256 and the enable divides by 4.

The frame clock is asynchronous to the master clock and is synchronised inside the block. The master clock is assumed to be frequency-locked to the frame clock.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is held and after its release, `locked` is 0, `ratio_code` is 00 and `bit_tick` stays low until a lock is reached or master mode is selected.
- R2: A frame period (master-clock cycles between consecutive synchronised rising edges of `frame_clk`) is accepted when it lies within ±2 cycles of 256, 384, 512 or 768. The accepted period is coded 00, 01, 10 or 11 respectively. A period 3 or more cycles from every nominal value is out of range.
- R3: In slave mode, `locked` rises once three consecutive accepted frames have given the same code.
- R4: While unlocked, `ratio_code` follows the code of the latest accepted frame. An out-of-range frame leaves it unchanged and restarts the three-frame count.
- R5: While locked, `ratio_code` holds the locked code. A single frame that is out of range or of a different code keeps the lock. Two such frames in a row drop `locked`. A matching frame clears the miss count.
- R6: If no synchronised rising edge follows the previous one within 770 master-clock cycles, that frame counts as out of range. The next rising edge only re-arms the measurement.
- R7: While `locked` is 1 in slave mode, `bit_tick` pulses for one cycle every 4, 6, 8 or 12 master-clock cycles for codes 00, 01, 10 and 11. While unlocked in slave mode, it stays low.
- R8: With `master_mode` at 1, `ratio_code` reads 00 at once and `bit_tick` pulses every 4 cycles. `locked` is 0 from the next cycle, and the lock history is cleared, so a return to slave mode needs three fresh accepted frames.
- R9: The first rising edge of `frame_clk` after reset starts the first measurement without producing one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Free-running master clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: block is frame master, ratio fixed at 256; 0: slave, ratio detected |
| frame_clk | input | 1 | Asynchronous frame (word-select) clock, one period per sample |
| ratio_code | output | 2 | 00=256, 01=384, 10=512, 11=768 master-clock cycles per frame |
| locked | output | 1 | Detected ratio is stable (slave mode only) |
| bit_tick | output | 1 | One-cycle enable at 64 times the sample rate |

## Verification
A rising edge of `frame_clk` passes two synchroniser stages and an edge register, and the measurement result is registered once more. `ratio_code` and `locked` therefore settle four master-clock edges after the frame input rises. The bench compares both against its own frame model halfway through every frame, at least 126 cycles after the edge, so it never samples inside that window. The effect of `master_mode` on `locked` is due one edge later and on `ratio_code` at once, and the bench checks both one full cycle after the switch. The spacing of `bit_tick` is checked by counting falling edges between two consecutive pulses while the lock is stable.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;

    localparam int RATIO_COUNT    = 4;
    localparam int BIT_CLOCK_MULT = 64;

    typedef enum logic [1:0] {
        RATIO_256 = 2'd0,
        RATIO_384 = 2'd1,
        RATIO_512 = 2'd2,
        RATIO_768 = 2'd3
    } ratio_e;

    // Master-clock cycles per frame for a ratio code.
    function automatic int nominal_cycles(input int idx);
        return (idx == RATIO_COUNT - 1) ? 768 : 128 * (idx + 2);
    endfunction

    // Divider that turns the master clock into the 64x frame-rate tick.
    function automatic int tick_divisor(input int idx);
        return nominal_cycles(idx) / BIT_CLOCK_MULT;
    endfunction

    localparam int MAX_NOMINAL = nominal_cycles(RATIO_COUNT - 1);

endpackage

// File: rtl/mrd_edge_sync.sv
`timescale 1ns/1ps
// Brings the asynchronous frame clock into the master-clock domain and
// flags its rising edge. STAGES must be 2 or more.
module mrd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/mrd_period_meas.sv
`timescale 1ns/1ps
// Counts master-clock cycles between synchronised frame edges and
// classifies each period against the nominal ratios.
module mrd_period_meas
    import mrd_pkg::*;
#(
    parameter int TOL = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise,
    output logic   meas_vld,
    output logic   meas_ok,
    output ratio_e meas_code
);

    localparam int LIMIT = MAX_NOMINAL + TOL;
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             vld;
        logic             ok;
        ratio_e           code;
    } meas_t;

    meas_t s_d, s_q;

    logic [CNT_W:0]           period;
    logic [RATIO_COUNT-1:0]   hit;
    ratio_e                   hit_code;

    assign period = {1'b0, s_q.cnt} + (CNT_W+1)'(1);

    for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_window
        localparam logic [CNT_W:0] LO_V = (CNT_W+1)'(nominal_cycles(g) - TOL);
        localparam logic [CNT_W:0] HI_V = (CNT_W+1)'(nominal_cycles(g) + TOL);
        assign hit[g] = (period >= LO_V) && (period <= HI_V);
    end

    always_comb begin
        hit_code = RATIO_256;
        for (int i = 0; i < RATIO_COUNT; i++) begin
            if (hit[i]) begin
                hit_code = ratio_e'(2'(i));
            end
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.ok  = 1'b0;
        if (rise) begin
            if (s_q.armed) begin
                s_d.vld  = 1'b1;
                s_d.ok   = |hit;
                s_d.code = hit_code;
            end
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (s_q.armed) begin
            if (s_q.cnt == LIMIT_V) begin
                s_d.vld   = 1'b1;
                s_d.ok    = 1'b0;
                s_d.armed = 1'b0;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign meas_vld  = s_q.vld;
    assign meas_ok   = s_q.ok;
    assign meas_code = s_q.code;

endmodule

// File: rtl/mrd_lock_track.sv
`timescale 1ns/1ps
// Hysteresis on the per-frame measurements: a run of equal codes locks,
// a run of misses unlocks.
module mrd_lock_track
    import mrd_pkg::*;
#(
    parameter int LOCK_N   = 3,
    parameter int UNLOCK_N = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   ev_vld,
    input  logic   ev_ok,
    input  ratio_e ev_code,
    output logic   locked,
    output ratio_e code_out
);

    localparam int MW = $clog2(LOCK_N + 1);
    localparam int XW = $clog2(UNLOCK_N + 1);
    localparam logic [MW-1:0] LOCK_V     = MW'(LOCK_N);
    localparam logic [XW-1:0] LAST_MISS  = XW'(UNLOCK_N - 1);

    typedef struct packed {
        logic           locked;
        ratio_e         out;
        ratio_e         cand;
        logic [MW-1:0]  match;
        logic [XW-1:0]  miss;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (ev_vld) begin
            if (ev_ok) begin
                if (s_q.match != '0 && ev_code == s_q.cand) begin
                    if (s_q.match != LOCK_V) begin
                        s_d.match = s_q.match + MW'(1);
                    end
                end else begin
                    s_d.cand  = ev_code;
                    s_d.match = MW'(1);
                end
                if (s_q.locked) begin
                    if (ev_code == s_q.out) begin
                        s_d.miss = '0;
                    end else if (s_q.miss == LAST_MISS) begin
                        s_d.locked = 1'b0;
                        s_d.miss   = '0;
                        s_d.out    = ev_code;
                    end else begin
                        s_d.miss = s_q.miss + XW'(1);
                    end
                end else begin
                    s_d.out = ev_code;
                    if (s_d.match == LOCK_V) begin
                        s_d.locked = 1'b1;
                        s_d.miss   = '0;
                    end
                end
            end else begin
                s_d.match = '0;
                if (s_q.locked) begin
                    if (s_q.miss == LAST_MISS) begin
                        s_d.locked = 1'b0;
                        s_d.miss   = '0;
                    end else begin
                        s_d.miss = s_q.miss + XW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign locked   = s_q.locked;
    assign code_out = s_q.out;

endmodule

// File: rtl/mrd_tick_div.sv
`timescale 1ns/1ps
// Divides the master clock by ratio/64 to give a 64x frame-rate enable.
module mrd_tick_div
    import mrd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  ratio_e sel,
    output logic   tick
);

    localparam int MAX_DIV = tick_divisor(RATIO_COUNT - 1);
    localparam int DW      = $clog2(MAX_DIV);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          tick;
    } div_t;

    div_t s_d, s_q;

    logic [DW-1:0] last_tab [RATIO_COUNT];
    logic [DW-1:0] last_v;

    for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_div
        assign last_tab[g] = DW'(tick_divisor(g) - 1);
    end

    assign last_v = last_tab[sel];

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b0;
        end else if (s_q.cnt >= last_v) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt  = s_q.cnt + DW'(1);
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick = s_q.tick;

endmodule

// File: rtl/mclk_ratio_detect.sv
`timescale 1ns/1ps
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int TOL           = 2,
    parameter int LOCK_FRAMES   = 3,
    parameter int UNLOCK_FRAMES = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       master_mode,
    input  logic       frame_clk,
    output logic [1:0] ratio_code,
    output logic       locked,
    output logic       bit_tick
);

    logic   ws_rise;
    logic   meas_vld;
    logic   meas_ok;
    ratio_e meas_code;
    logic   trk_locked;
    ratio_e trk_code;
    ratio_e eff_code;

    mrd_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (mclk),
        .rst_n    (rst_n),
        .async_in (frame_clk),
        .rise     (ws_rise)
    );

    mrd_period_meas #(
        .TOL (TOL)
    ) i_meas (
        .clk       (mclk),
        .rst_n     (rst_n),
        .rise      (ws_rise),
        .meas_vld  (meas_vld),
        .meas_ok   (meas_ok),
        .meas_code (meas_code)
    );

    mrd_lock_track #(
        .LOCK_N   (LOCK_FRAMES),
        .UNLOCK_N (UNLOCK_FRAMES)
    ) i_track (
        .clk      (mclk),
        .rst_n    (rst_n),
        .clear    (master_mode),
        .ev_vld   (meas_vld),
        .ev_ok    (meas_ok),
        .ev_code  (meas_code),
        .locked   (trk_locked),
        .code_out (trk_code)
    );

    assign eff_code = master_mode ? RATIO_256 : trk_code;

    mrd_tick_div i_div (
        .clk    (mclk),
        .rst_n  (rst_n),
        .enable (master_mode | trk_locked),
        .sel    (eff_code),
        .tick   (bit_tick)
    );

    assign ratio_code = eff_code;
    assign locked     = trk_locked;

endmodule

// File: rtl/mrd_checker.sv
`timescale 1ns/1ps
module mrd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       master_mode,
    input logic [1:0] ratio_code,
    input logic       locked,
    input logic       bit_tick,
    input logic       meas_vld,
    input logic       meas_ok
);

    // R7: a tick only follows a cycle in which the divider was enabled
    p_tick_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(locked || master_mode));

    // R7: the shortest divider is 4, so ticks never sit back to back
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R8: master mode clears the lock on the following edge
    p_master_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_mode) |-> !locked);

    // R3: a lock is only gained right after an accepted measurement
    p_lock_on_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_vld && meas_ok));

    // R5: a lock is only lost after a measurement or a switch to master
    p_drop_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(meas_vld || master_mode));

    // R5: the code does not move while the lock persists in slave mode
    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked) && !master_mode && !$past(master_mode))
            |-> ratio_code == $past(ratio_code));

endmodule

bind mclk_ratio_detect mrd_checker i_mrd_checker (
    .clk         (mclk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .ratio_code  (ratio_code),
    .locked      (locked),
    .bit_tick    (bit_tick),
    .meas_vld    (meas_vld),
    .meas_ok     (meas_ok)
);

// File: tb/test_mclk_ratio_detect.sv
`timescale 1ns/1ps
module test_mclk_ratio_detect;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_mode = 1'b0;
    logic       frame_clk = 1'b0;
    logic [1:0] ratio_code;
    logic       locked;
    logic       bit_tick;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference frame model built from the requirements.
    int m_locked, m_out, m_cand, m_match, m_miss, m_armed, m_prevp;

    always #4 mclk = ~mclk;

    mclk_ratio_detect i_mclk_ratio_detect (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .frame_clk   (frame_clk),
        .ratio_code  (ratio_code),
        .locked      (locked),
        .bit_tick    (bit_tick)
    );

    function automatic int nom(int k);
        return (k == 3) ? 768 : 128 * (k + 2);
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_locked = 0; m_out = 0; m_cand = 0; m_match = 0; m_miss = 0;
    endtask

    // R2 window, R3 lock run, R4 follow, R5 miss hysteresis
    task automatic model_event(int p);
        int ok = 0;
        int c  = 0;
        for (int k = 0; k < 4; k++) begin
            if (p >= nom(k) - 2 && p <= nom(k) + 2) begin
                ok = 1;
                c  = k;
            end
        end
        if (ok != 0) begin
            if (m_match > 0 && c == m_cand) begin
                if (m_match < 3) m_match++;
            end else begin
                m_cand  = c;
                m_match = 1;
            end
            if (m_locked != 0) begin
                if (c == m_out) m_miss = 0;
                else if (m_miss == 1) begin
                    m_locked = 0; m_miss = 0; m_out = c;
                end else m_miss++;
            end else begin
                m_out = c;
                if (m_match == 3) begin
                    m_locked = 1; m_miss = 0;
                end
            end
        end else begin
            m_match = 0;
            if (m_locked != 0) begin
                if (m_miss == 1) begin
                    m_locked = 0; m_miss = 0;
                end else m_miss++;
            end
        end
    endtask

    // R9: the first edge only arms; R6: a late edge is an out-of-range frame
    task automatic model_rise(int len);
        if (m_armed != 0 && !master_mode) model_event(m_prevp);
        m_armed = 1;
        m_prevp = len;
    endtask

    task automatic check_state(string req);
        check_eq({req, " ratio_code"}, int'(ratio_code), master_mode ? 0 : m_out);
        check_eq({req, " locked"}, int'(locked), master_mode ? 0 : m_locked);
    endtask

    task automatic drive_frames(int p, int n, int extra, string req);
        for (int i = 0; i < n; i++) begin
            int len = p + ((i == n - 1) ? extra : 0);
            frame_clk = 1'b1;
            model_rise(len);
            repeat (p / 2) @(negedge mclk);
            check_state(req);
            frame_clk = 1'b0;
            repeat (len - p / 2) @(negedge mclk);
        end
    endtask

    task automatic measure_tick(int exp, string req);
        int waited = 0;
        int gap    = 0;
        while (!bit_tick && waited < 40) begin
            @(negedge mclk);
            waited++;
        end
        @(negedge mclk);
        gap = 1;
        while (!bit_tick && gap < 40) begin
            @(negedge mclk);
            gap++;
        end
        check_eq(req, gap, exp);
    endtask

    task automatic count_ticks(int cycles, int exp, string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge mclk);
            if (bit_tick) seen++;
        end
        check_eq(req, seen, exp);
    endtask

    initial begin
        repeat (190000) @(posedge mclk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        m_armed = 0;
        m_prevp = 0;

        // R1: reset state
        repeat (3) @(negedge mclk);
        check_eq("R1 locked in reset", int'(locked), 0);
        check_eq("R1 code in reset", int'(ratio_code), 0);
        count_ticks(8, 0, "R1 ticks in reset");
        rst_n = 1'b1;
        count_ticks(20, 0, "R1 ticks after reset");
        check_state("R1");

        // R3, R9: lock on 512 after the arming edge and three equal frames
        drive_frames(512, 5, 0, "R3");
        check_eq("R3 locked 512", int'(locked), 1);
        fork
            drive_frames(512, 2, 0, "R7");
            begin
                repeat (100) @(negedge mclk);
                measure_tick(8, "R7 divide by 8");
            end
        join

        // R4, R5: ratio change to 384 unlocks after two misses, then relocks
        drive_frames(384, 7, 0, "R5");
        check_eq("R4 code 384", int'(ratio_code), 1);
        fork
            drive_frames(384, 1, 0, "R7");
            begin
                repeat (50) @(negedge mclk);
                measure_tick(6, "R7 divide by 6");
            end
        join

        // R5: one bad frame keeps the lock
        drive_frames(300, 1, 0, "R5");
        drive_frames(384, 3, 0, "R5");
        check_eq("R5 single glitch keeps lock", int'(locked), 1);
        check_eq("R5 single glitch keeps code", int'(ratio_code), 1);

        // R2: sweep of every nominal ratio across the tolerance edges
        for (int k = 0; k < 4; k++) begin
            for (int d = -3; d <= 3; d++) begin
                drive_frames(nom(k) + d, 4, 0, "R2");
            end
        end

        // R7: divide by 12 at 768
        drive_frames(768, 4, 0, "R3");
        check_eq("R3 locked 768", int'(locked), 1);
        fork
            drive_frames(768, 1, 0, "R7");
            begin
                repeat (50) @(negedge mclk);
                measure_tick(12, "R7 divide by 12");
            end
        join

        // R6: one missing edge counts once and the lock survives
        drive_frames(768, 1, 1500, "R6");
        drive_frames(768, 3, 0, "R6");
        check_eq("R6 one timeout keeps lock", int'(locked), 1);

        // R6: repeated overlong frames drop the lock; R7 ticks stop
        drive_frames(1000, 3, 0, "R6");
        check_eq("R6 overlong frames unlock", int'(locked), 0);
        count_ticks(30, 0, "R7 no ticks unlocked");

        // R9: after a fresh reset the first edge only arms
        rst_n = 1'b0;
        repeat (3) @(negedge mclk);
        model_clear();
        m_armed = 0;
        rst_n = 1'b1;
        @(negedge mclk);
        drive_frames(512, 1, 0, "R9");
        check_eq("R9 first edge no code", int'(ratio_code), 0);
        drive_frames(512, 4, 0, "R9");
        check_eq("R9 locked after arming", int'(locked), 1);

        // R8: master mode forces 256 and clears the lock
        master_mode = 1'b1;
        model_clear();
        @(negedge mclk);
        check_eq("R8 master code", int'(ratio_code), 0);
        check_eq("R8 master unlocked", int'(locked), 0);
        fork
            drive_frames(512, 3, 0, "R8");
            begin
                repeat (20) @(negedge mclk);
                measure_tick(4, "R8 master divide by 4");
            end
        join
        master_mode = 1'b0;
        @(negedge mclk);
        check_eq("R8 slave again unlocked", int'(locked), 0);
        drive_frames(512, 4, 0, "R8");
        check_eq("R8 relock needs fresh frames", int'(locked), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule